// File: doc/BRIEF.md
# Undefined Opcode Trap Controller

This block sits next to the opcode fetch path of a byte-oriented processor and turns the fetch of an opcode that the decoder does not recognise into a trap that cannot be masked. It watches the fetch strobe and the decoder's undefined-opcode flag. It also watches the acknowledge cycle of external interrupt 0 when interrupt mode 0 is selected, because the interrupting device supplies an opcode in that cycle. When it detects a fault, it sends a one-cycle trap request to the sequencer. In the same cycle it asks for the faulting program counter to be pushed and presents the restart vector, which is also the reset vector.

A one-byte control/status register tells a restart caused by a trap apart from a cold reset. It also records whether the faulting byte was the second or the third byte of the opcode. The handler uses that to rewind the stacked PC to the start of the bad instruction: it subtracts 1 for a second-byte fault and 2 for a third-byte fault. A trap pre-empts a maskable interrupt that is requested in the same cycle, and the maskable enable has no effect on the trap.

Top module: `optrap_ctrl`

## Requirements
- R1: After reset, `trap_req`, `push_req` and `irq_take` are 0 and `csr_rdata` reads 0x00.
- R2: When `undef_op` is 1 together with `fetch_stb` at a clock edge, `trap_req` is 1 for exactly the following cycle, whatever the value of `ie_flag`.
- R3: When `undef_op` is 1 together with `ack_m0` at a clock edge, a trap is raised in the same way. `undef_op` without a strobe or acknowledge raises nothing, and neither does a strobe without `undef_op`.
- R4: `push_req` equals `trap_req`, and during the trap cycle `push_pc` holds the `pc` value sampled at the detecting edge.
- R5: `trap_vector` reads 0x0000, the reset vector, during every trap cycle.
- R6: The trap status bit, bit 7 of `csr_rdata`, reads 1 from the trap cycle onwards. A register write with bit 7 = 0 clears it. A write with bit 7 = 1 has no effect.
- R7: The fault-position bit, bit 6 of `csr_rdata`, is loaded on each trap with 1 for a third-byte fault (`fetch_pos` = 2) and with 0 for a second-byte (`fetch_pos` = 1) or first-byte (`fetch_pos` = 0) fault. Register writes never change it. Bits 5..0 read 0.
- R8: `irq_take` equals `irq_req & ie_flag`, except in a trap cycle, when it is 0.
- R9: A fault detected in the cycle where `trap_req` is 1 is ignored: it raises no further trap and captures no PC.
- R10: If a trap is taken in the same cycle as a write that clears bit 7, the bit reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_stb | input | 1 | Opcode fetch cycle in progress |
| fetch_pos | input | 2 | Opcode byte being fetched: 0 first, 1 second, 2 third |
| ack_m0 | input | 1 | Interrupt-0 acknowledge cycle in mode 0 |
| undef_op | input | 1 | Decoder flags the fetched opcode as undefined |
| pc | input | PC_W | Current program counter |
| irq_req | input | 1 | Maskable interrupt request |
| ie_flag | input | 1 | Maskable interrupt enable |
| csr_we | input | 1 | Write strobe for the control/status register |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Register read value |
| trap_req | output | 1 | One-cycle trap request to the sequencer |
| push_req | output | 1 | Request to push `push_pc` on the stack |
| push_pc | output | PC_W | PC value to push |
| trap_vector | output | PC_W | Restart address for the trap |
| irq_take | output | 1 | Maskable interrupt accepted this cycle |

## Verification
The assertions assume that `fetch_pos` never carries the unused code 3. They also assume that `pc` and the fault inputs are stable across each clock edge, so that the value sampled at the detecting edge is the value to push. The stimulus drives every input on the falling edge and holds it for a full cycle. It sweeps all combinations of strobe, acknowledge, undefined flag, byte position, enable and maskable request, using only position codes 0 to 2. Between sweep points it returns the status bit to 0 through the register write path, so each trap starts from a known register value.

// File: rtl/optrap_pkg.sv
package optrap_pkg;

   typedef enum logic [1:0] {
      POS_FIRST  = 2'd0,
      POS_SECOND = 2'd1,
      POS_THIRD  = 2'd2
   } byte_pos_e;

   function automatic logic pos_is_late(input logic [1:0] pos);
      return pos == POS_THIRD;
   endfunction

endpackage

// File: rtl/optrap_detect.sv
module optrap_detect
   import optrap_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fetch_stb,
   input  logic [1:0]      fetch_pos,
   input  logic            ack_m0,
   input  logic            undef_op,
   input  logic [PC_W-1:0] pc,
   output logic            hit_acc,
   output logic            hit_late,
   output logic            trap_req,
   output logic [PC_W-1:0] saved_pc
);

   logic            trap_q;
   logic [PC_W-1:0] pc_q;
   logic            hit_raw;

   assign hit_raw  = undef_op & (fetch_stb | ack_m0);
   assign hit_acc  = hit_raw & ~trap_q;
   assign hit_late = pos_is_late(fetch_pos);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_q <= 1'b0;
         pc_q   <= '0;
      end else begin
         trap_q <= hit_acc;
         if (hit_acc) pc_q <= pc;
      end
   end

   assign trap_req = trap_q;
   assign saved_pc = pc_q;

   assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (undef_op && (fetch_stb || ack_m0) && !trap_req) |=> trap_req);

   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> !trap_req);

   assert_no_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(undef_op && (fetch_stb || ack_m0)) |=> !trap_req);

   assert_pos_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stb |-> fetch_pos != 2'd3);

endmodule

// File: rtl/optrap_csr.sv
module optrap_csr #(
   parameter int DATA_W   = 8,
   parameter int TRAP_BIT = 7,
   parameter int UFO_BIT  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_trap,
   input  logic              set_late,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic trap_q;
   logic late_q;
   logic clr_trap;
   logic unused_wbits;

   assign clr_trap     = we & ~wdata[TRAP_BIT];
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_q <= 1'b0;
         late_q <= 1'b0;
      end else begin
         if (set_trap)      trap_q <= 1'b1;
         else if (clr_trap) trap_q <= 1'b0;
         if (set_trap)      late_q <= set_late;
      end
   end

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rbit
      if (gi == TRAP_BIT) begin : g_trap
         assign rdata[gi] = trap_q;
      end else if (gi == UFO_BIT) begin : g_late
         assign rdata[gi] = late_q;
      end else begin : g_zero
         assign rdata[gi] = 1'b0;
      end
   end

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_trap |=> trap_q);

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_q && !(we && !wdata[TRAP_BIT])) |=> trap_q);

   assert_no_self_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_q && !set_trap) |=> !trap_q);

   assert_late_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !set_trap |=> $stable(late_q));

endmodule

// File: rtl/optrap_arb.sv
module optrap_arb #(
   parameter int              PC_W     = 16,
   parameter logic [PC_W-1:0] VEC_ADDR = '0
) (
   input  logic            trap_req,
   input  logic [PC_W-1:0] saved_pc,
   input  logic            irq_req,
   input  logic            ie_flag,
   output logic            push_req,
   output logic [PC_W-1:0] push_pc,
   output logic [PC_W-1:0] trap_vector,
   output logic            irq_take
);

   assign push_req    = trap_req;
   assign push_pc     = saved_pc;
   assign trap_vector = VEC_ADDR;
   assign irq_take    = irq_req & ie_flag & ~trap_req;

endmodule

// File: rtl/optrap_ctrl.sv
module optrap_ctrl #(
   parameter int PC_W     = 16,
   parameter int DATA_W   = 8,
   parameter int TRAP_BIT = 7,
   parameter int UFO_BIT  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_stb,
   input  logic [1:0]        fetch_pos,
   input  logic              ack_m0,
   input  logic              undef_op,
   input  logic [PC_W-1:0]   pc,
   input  logic              irq_req,
   input  logic              ie_flag,
   input  logic              csr_we,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   output logic              trap_req,
   output logic              push_req,
   output logic [PC_W-1:0]   push_pc,
   output logic [PC_W-1:0]   trap_vector,
   output logic              irq_take
);

   localparam logic [PC_W-1:0] RST_VEC = '0;

   if (PC_W < 8) begin : g_chk_pc
      $error("optrap_ctrl: PC_W must be at least 8");
   end
   if (TRAP_BIT >= DATA_W || UFO_BIT >= DATA_W) begin : g_chk_bits
      $error("optrap_ctrl: status bit outside register");
   end
   if (TRAP_BIT == UFO_BIT) begin : g_chk_overlap
      $error("optrap_ctrl: status bits overlap");
   end

   logic            hit_acc;
   logic            hit_late;
   logic            trap_int;
   logic [PC_W-1:0] saved_pc;

   optrap_detect #(.PC_W(PC_W)) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetch_stb (fetch_stb),
      .fetch_pos (fetch_pos),
      .ack_m0    (ack_m0),
      .undef_op  (undef_op),
      .pc        (pc),
      .hit_acc   (hit_acc),
      .hit_late  (hit_late),
      .trap_req  (trap_int),
      .saved_pc  (saved_pc)
   );

   optrap_csr #(
      .DATA_W   (DATA_W),
      .TRAP_BIT (TRAP_BIT),
      .UFO_BIT  (UFO_BIT)
   ) u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_trap (hit_acc),
      .set_late (hit_late),
      .we       (csr_we),
      .wdata    (csr_wdata),
      .rdata    (csr_rdata)
   );

   optrap_arb #(.PC_W(PC_W), .VEC_ADDR(RST_VEC)) u_arb (
      .trap_req    (trap_int),
      .saved_pc    (saved_pc),
      .irq_req     (irq_req),
      .ie_flag     (ie_flag),
      .push_req    (push_req),
      .push_pc     (push_pc),
      .trap_vector (trap_vector),
      .irq_take    (irq_take)
   );

   assign trap_req = trap_int;

   assert_push_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (push_req && push_pc == $past(pc)));

   assert_trap_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> !irq_take);

   assert_status_on_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> csr_rdata[TRAP_BIT]);

endmodule

// File: tb/optrap_ctrl_tb.sv
module optrap_ctrl_tb;

   localparam int PC_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fetch_stb = 1'b0;
   logic [1:0]        fetch_pos = 2'd0;
   logic              ack_m0 = 1'b0;
   logic              undef_op = 1'b0;
   logic [PC_W-1:0]   pc = '0;
   logic              irq_req = 1'b0;
   logic              ie_flag = 1'b0;
   logic              csr_we = 1'b0;
   logic [7:0]        csr_wdata = '0;
   logic [7:0]        csr_rdata;
   logic              trap_req;
   logic              push_req;
   logic [PC_W-1:0]   push_pc;
   logic [PC_W-1:0]   trap_vector;
   logic              irq_take;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   optrap_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .fetch_pos(fetch_pos),
      .ack_m0(ack_m0), .undef_op(undef_op), .pc(pc), .irq_req(irq_req),
      .ie_flag(ie_flag), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .trap_req(trap_req), .push_req(push_req),
      .push_pc(push_pc), .trap_vector(trap_vector), .irq_take(irq_take)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] reg_exp(input bit t, input bit u);
      return {t, u, 6'b0};
   endfunction

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      csr_we = 1'b1;
      csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
      #1;
   endtask

   bit trap_m = 0;
   bit late_m = 0;

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(trap_req == 0 && push_req == 0 && irq_take == 0, "R1", trap_req, 0);
      check(csr_rdata == 8'h00, "R1", csr_rdata, 0);
      rst_n = 1'b1;

      // write 1 to the status bit with no trap pending: ignored (R6)
      wr(8'hFF);
      check(csr_rdata == 8'h00, "R6", csr_rdata, 0);

      for (int idx = 0; idx < 96; idx++) begin
         bit stb = idx[0];
         bit ack = idx[1];
         bit und = idx[2];
         bit ie  = idx[3];
         bit irq = idx[4];
         int pos = idx / 32;
         bit hit = und & (stb | ack);
         logic [PC_W-1:0] p = PC_W'(16'h1234 + idx * 16'd517);
         @(negedge clk);
         fetch_stb = stb; ack_m0 = ack; undef_op = und;
         fetch_pos = 2'(pos); pc = p; ie_flag = ie; irq_req = 1'b0;
         @(negedge clk);
         fetch_stb = 0; ack_m0 = 0; undef_op = 0; irq_req = irq;
         pc = ~p;
         #1;
         if (hit) begin trap_m = 1; late_m = (pos == 2); end
         check(trap_req == hit, stb ? "R2" : "R3", trap_req, hit);
         check(push_req == hit, "R4", push_req, hit);
         if (hit) begin
            check(push_pc == p, "R4", push_pc, p);
            check(trap_vector == 16'h0000, "R5", trap_vector, 0);
         end
         check(irq_take == (irq & ie & ~hit), "R8", irq_take, irq & ie & ~hit);
         check(csr_rdata == reg_exp(trap_m, late_m), "R7", csr_rdata, reg_exp(trap_m, late_m));
         @(negedge clk);
         irq_req = 0;
         #1;
         check(trap_req == 0, "R2", trap_req, 0);
         check(csr_rdata[7] == trap_m, "R6", csr_rdata, reg_exp(trap_m, late_m));
         // clear status; write 1s elsewhere to show the position bit ignores writes
         wr(8'h7F);
         trap_m = 0;
         check(csr_rdata == reg_exp(0, late_m), "R7", csr_rdata, reg_exp(0, late_m));
      end

      // status stays set across idle cycles (R6)
      @(negedge clk);
      fetch_stb = 1; undef_op = 1; fetch_pos = 2'd1; pc = 16'hA000;
      @(negedge clk);
      fetch_stb = 0; undef_op = 0;
      repeat (5) @(negedge clk);
      #1;
      check(csr_rdata == 8'h80, "R6", csr_rdata, 8'h80);
      wr(8'h80);
      check(csr_rdata == 8'h80, "R6", csr_rdata, 8'h80);
      wr(8'h00);
      check(csr_rdata == 8'h00, "R6", csr_rdata, 0);

      // fault in the trap cycle is ignored (R9)
      @(negedge clk);
      fetch_stb = 1; undef_op = 1; fetch_pos = 2'd2; pc = 16'hB111;
      @(negedge clk);
      fetch_pos = 2'd1; pc = 16'hC222;
      #1;
      check(trap_req == 1 && push_pc == 16'hB111, "R9", push_pc, 16'hB111);
      @(negedge clk);
      fetch_stb = 0; undef_op = 0;
      #1;
      check(trap_req == 0, "R9", trap_req, 0);
      check(push_pc == 16'hB111, "R9", push_pc, 16'hB111);
      check(csr_rdata == 8'hC0, "R9", csr_rdata, 8'hC0);

      // trap and clearing write in the same cycle: set wins (R10)
      wr(8'h00);
      @(negedge clk);
      ack_m0 = 1; undef_op = 1; fetch_pos = 2'd1; pc = 16'h0042;
      csr_we = 1; csr_wdata = 8'h00;
      @(negedge clk);
      ack_m0 = 0; undef_op = 0; csr_we = 0;
      #1;
      check(csr_rdata == 8'h80, "R10", csr_rdata, 8'h80);
      check(trap_req == 1 && push_pc == 16'h0042, "R3", push_pc, 16'h0042);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule